// File: doc/BRIEF.md
# Eight-Channel V-Profile LED Dimmer

The block drives eight LED lines with pulse-width modulation. An 8-bit switch value sets the duty of channel 0 directly. The other seven duty values are derived from that one value, so the eight brightness levels form a V-shaped profile. The dimmest channel sits at an index chosen by the `PIVOT` parameter when the design is elaborated. Each step away from that index, in either direction, adds `STEP` counts of duty, and derived values clip at the ends of the counter range. The switch input and the LED lines are plain level signals with no handshake, so back-pressure does not apply.

Each channel has its own free-running counter, instantiated as a separate submodule, and a duty register. A line is high while its counter is below the channel's duty register. A new duty value is taken into the register only on the clock edge where the counter wraps to zero, so every period is whole. All counters clear together on reset and then stay in lockstep, so all eight periods begin on the same edge.

Top module: `led_ramp_pwm`

## Requirements
- R1: While reset is high and through the first full period after it, every LED line is low: duty registers clear to 0 and all counters clear to 0.
- R2: Channel 0's high time per 256-clock period equals the switch value.
- R3: A channel i with i <= PIVOT has duty `base - STEP*i`, where `base` is the switch value.
- R4: A channel i with i > PIVOT has duty `base - STEP*PIVOT + STEP*(i - PIVOT)`.
- R5: A derived duty that falls below 0 is held at 0, and one that rises above 255 is held at 255. It does not wrap.
- R6: A line is high while its counter (0..255) is below its duty. Duty 0 gives no high cycles. Duty 255 gives 255 high cycles and one low cycle, the one at counter value 255.
- R7: A switch change takes effect only at the next wrap of the counter to 0. The period in progress keeps its old duty.
- R8: All counters run in lockstep from reset. Each channel's high time is one contiguous run starting at counter value 0.
- R9: When no derived value clips, brightness strictly decreases from channel 0 to channel PIVOT and strictly increases from channel PIVOT to channel 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_level | input | CW (8) | Base duty value for channel 0 |
| led_pwm | output | NCH (8) | PWM line for each channel, bit i drives channel i |

## Verification
Every cycle, assertions check that each duty register changes only on a wrap edge, that duty 0 and the wrap cycle keep a line low, and that every counter matches channel 0's counter. They also check that the counter returns to zero after its maximum, that channel 0's target equals the switch value, and that each slope of the profile never turns the wrong way. Other behaviours can only be shown by the bench scenarios: the exact high count per period, the strict ordering when nothing clips, clipping at both ends, the all-low first period after reset, and the fact that a switch change in mid-period leaves the current period intact. The bench shows these on three builds with different pivots and steps, across a sweep of switch values.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  localparam int unsigned NCH_DEF  = 8;
  localparam int unsigned CW_DEF   = 8;
  localparam int unsigned STEP_DEF = 16;

  // Clip a signed value into [lo, hi].
  function automatic int clamp(input int v, input int lo, input int hi);
    if (v < lo)      return lo;
    else if (v > hi) return hi;
    else             return v;
  endfunction
endpackage

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int unsigned CW = ramp_pkg::CW_DEF
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CW'(1);
  end

  assign wrap = (cnt == TOP);

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (cnt == '0));
endmodule

// File: rtl/duty_channel.sv
module duty_channel #(
  parameter int unsigned CW = ramp_pkg::CW_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] duty_in,
  output logic          pwm,
  output logic [CW-1:0] phase
);
  logic          at_wrap;
  logic [CW-1:0] duty_q;

  wrap_counter #(.CW(CW)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .cnt  (phase),
    .wrap (at_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)          duty_q <= '0;
    else if (at_wrap) duty_q <= duty_in;
  end

  assign pwm = (phase < duty_q);

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !at_wrap |=> $stable(duty_q));
  // R6
  off_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (duty_q == '0) |-> !pwm);
  // R6
  wrap_gap_chk: assert property (@(posedge clk) disable iff (rst)
    at_wrap |-> !pwm);
endmodule

// File: rtl/vee_profile.sv
module vee_profile #(
  parameter int unsigned NCH   = ramp_pkg::NCH_DEF,
  parameter int unsigned CW    = ramp_pkg::CW_DEF,
  parameter int unsigned PIVOT = 0,
  parameter int unsigned STEP  = ramp_pkg::STEP_DEF
) (
  input  logic [CW-1:0]           base,
  output logic [NCH-1:0][CW-1:0]  duty
);
  localparam int MAXV = (1 << CW) - 1;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // Offset of channel g from the base value: falls by STEP per index
    // down to the pivot, then climbs by STEP per index past it.
    localparam int OFF = (g <= PIVOT) ? -(int'(STEP) * g)
                                      : int'(STEP) * (g - 2 * int'(PIVOT));
    always_comb begin
      duty[g] = CW'(ramp_pkg::clamp(int'(base) + OFF, 0, MAXV));
    end
  end
endmodule

// File: rtl/led_ramp_pwm.sv
module led_ramp_pwm #(
  parameter int unsigned NCH   = ramp_pkg::NCH_DEF,
  parameter int unsigned CW    = ramp_pkg::CW_DEF,
  parameter int unsigned PIVOT = 0,
  parameter int unsigned STEP  = ramp_pkg::STEP_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  sw_level,
  output logic [NCH-1:0] led_pwm
);
  logic [NCH-1:0][CW-1:0] duty_w;
  logic [NCH-1:0][CW-1:0] phase_w;

  vee_profile #(.NCH(NCH), .CW(CW), .PIVOT(PIVOT), .STEP(STEP)) u_prof (
    .base (sw_level),
    .duty (duty_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    duty_channel #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .duty_in (duty_w[g]),
      .pwm     (led_pwm[g]),
      .phase   (phase_w[g])
    );

    // R8
    phase_sync_chk: assert property (@(posedge clk) disable iff (rst)
      phase_w[g] == phase_w[0]);

    if (g + 1 < NCH) begin : g_ord
      if (g < PIVOT) begin : g_fall
        // R9
        fall_order_chk: assert property (@(posedge clk) disable iff (rst)
          duty_w[g] >= duty_w[g+1]);
      end else begin : g_rise
        // R9
        rise_order_chk: assert property (@(posedge clk) disable iff (rst)
          duty_w[g+1] >= duty_w[g]);
      end
    end
  end

  // R2
  base_pass_chk: assert property (@(posedge clk) disable iff (rst)
    duty_w[0] == sw_level);
  // R1
  reset_dark_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (led_pwm == '0));
endmodule

// File: tb/test_led_ramp_pwm.sv
module test_led_ramp_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 8;
  localparam int CW   = 8;
  localparam int NDUT = 3;
  localparam int PER  = 256;
  localparam int PIV[NDUT] = '{3, 0, 7};
  localparam int STP[NDUT] = '{16, 30, 16};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] sw = '0;
  logic [NCH-1:0] led [NDUT];

  int tests = 0;
  int fails = 0;
  int ph = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Counter model from R1/R8: clears in reset, counts modulo 256.
  always @(posedge clk) ph <= rst ? 0 : (ph + 1) % PER;

  led_ramp_pwm #(.NCH(NCH), .CW(CW), .PIVOT(3), .STEP(16)) i_led_ramp_pwm (
    .clk(clk), .rst(rst), .sw_level(sw), .led_pwm(led[0]));
  led_ramp_pwm #(.NCH(NCH), .CW(CW), .PIVOT(0), .STEP(30)) i_led_ramp_pwm_p0 (
    .clk(clk), .rst(rst), .sw_level(sw), .led_pwm(led[1]));
  led_ramp_pwm #(.NCH(NCH), .CW(CW), .PIVOT(7), .STEP(16)) i_led_ramp_pwm_p7 (
    .clk(clk), .rst(rst), .sw_level(sw), .led_pwm(led[2]));

  function automatic int raw_duty(int base, int ch, int piv, int step);
    if (ch <= piv) return base - step * ch;
    return base - step * piv + step * (ch - piv);
  endfunction

  function automatic int exp_duty(int base, int ch, int piv, int step);
    int v = raw_duty(base, ch, piv, step);
    if (v < 0)   v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Measure one full period that starts at the next counter value 0.
  task automatic measure(int base, int chg_at, int nb);
    int cnt [NDUT][NCH];
    int bad [NDUT][NCH];
    for (int d = 0; d < NDUT; d++)
      for (int c = 0; c < NCH; c++) begin
        cnt[d][c] = 0;
        bad[d][c] = 0;
      end
    do @(negedge clk); while (ph != 0);
    for (int p = 0; p < PER; p++) begin
      if (p > 0) @(negedge clk);
      for (int d = 0; d < NDUT; d++)
        for (int c = 0; c < NCH; c++) begin
          if (led[d][c]) cnt[d][c]++;
          if (led[d][c] != (p < exp_duty(base, c, PIV[d], STP[d]))) bad[d][c]++;
        end
      if (p == chg_at) sw = CW'(nb);
    end
    for (int d = 0; d < NDUT; d++) begin
      bit ord_ok = 1'b1;
      bit unclipped = 1'b1;
      for (int c = 0; c < NCH; c++) begin
        int e = exp_duty(base, c, PIV[d], STP[d]);
        int r = raw_duty(base, c, PIV[d], STP[d]);
        string req;
        if (r < 0 || r > 255) unclipped = 1'b0;
        if (chg_at >= 0)            req = "R7";
        else if (c == 0)            req = "R2";
        else if (r < 0 || r > 255)  req = "R5";
        else if (e == 0 || e == 255) req = "R6";
        else if (c <= PIV[d])       req = "R3";
        else                        req = "R4";
        check(cnt[d][c] == e, req, $sformatf("dut%0d ch%0d base%0d high count", d, c, base),
              cnt[d][c], e);
        check(bad[d][c] == 0, "R8", $sformatf("dut%0d ch%0d base%0d phase mismatches", d, c, base),
              bad[d][c], 0);
      end
      if (unclipped) begin
        for (int c = 0; c + 1 < NCH; c++) begin
          if (c < PIV[d]) begin
            if (!(cnt[d][c] > cnt[d][c+1])) ord_ok = 1'b0;
          end else begin
            if (!(cnt[d][c+1] > cnt[d][c])) ord_ok = 1'b0;
          end
        end
        check(ord_ok, "R9", $sformatf("dut%0d base%0d strict V ordering", d, base),
              int'(ord_ok), 1);
      end
    end
  endtask

  task automatic apply(int base);
    @(negedge clk);
    sw = CW'(base);
    measure(base, -1, 0);
  endtask

  initial begin
    int highs;
    rst = 1'b1;
    sw = 8'd77;
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      for (int d = 0; d < NDUT; d++) highs += $countones(led[d]);
    end
    check(highs == 0, "R1", "high samples during reset", highs, 0);
    rst = 1'b0;
    highs = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      for (int d = 0; d < NDUT; d++) highs += $countones(led[d]);
    end
    check(highs == 0, "R1", "high samples in first period after reset", highs, 0);

    for (int b = 0; b <= 255; b += 15) apply(b);
    apply(255);
    apply(1);
    apply(112);
    apply(0);

    // R7: switch change in the middle of a period.
    apply(200);
    measure(200, 100, 40);
    measure(40, -1, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule